// File: doc/BRIEF.md
# Hybrid multicarrier PWM gate generator

This block drives the eight gate signals of a single-phase inverter. The inverter is built from two H-bridge cells in series, so the output can take five levels: +2V, +V, 0, -V and -2V. The block uses hybrid modulation. A slow square pulse at the fundamental frequency decides the polarity of each cell. A carrier-based sine PWM decides when each cell leaves its zero state.

A 32-bit phase accumulator produces the fundamental reference. A quarter-wave table gives the rectified sine magnitude. That magnitude is scaled by the modulation index and compared against two triangular carriers. The lower carrier spans 0 to Amax. The upper carrier sits one amplitude higher and runs in opposite phase to the lower one.

A square wave at half the fundamental rate chooses which zero state a cell rests in. The bridge output is zero in both states, but one closes both upper switches and the other closes both lower switches. The two PWM streams are exchanged between the cells every two fundamental periods, so that both cells carry the same share of the switching work. The tuning words and the modulation index are captured only at the start of each fundamental period.

Top module: `hpwm_gate_gen`

## Requirements
- R1: The combined output level, taken as the sum of the two cell levels, always lies in {-2,-1,0,+1,+2}. At unity index (`mod_idx_i` = 256), all five levels occur within one fundamental period. A cell's level is (left upper switch) minus (right upper switch). The gate bits are grouped per cell, four bits each, with cell 0 in bits 3:0 and cell 1 in bits 7:4. Within a cell, bit 0 is the left upper switch, bit 1 the left lower, bit 2 the right upper and bit 3 the right lower.
- R2: In every cycle, the lower switch of each leg is the complement of the upper switch of that leg.
- R3: While reset is held, every upper switch is off and every lower switch is on (`gate_o` = 8'hAA).
- R4: In the first half of each fundamental period, no cell level is negative. In the second half, no cell level is positive. A period starts when the accumulator wraps.
- R5: Each cell rests in a zero state chosen by the sequential pulse: both lower switches on in one fundamental period, both upper switches on in the next. The pulse toggles once per period, so its rate is half the fundamental rate. With a tuning word of 2^22, each of its half-periods lasts 1024 cycles.
- R6: The lower stream is on while the reference exceeds a triangle that runs between 0 and Amax = 4095. The upper stream is on while the reference exceeds 2*Amax minus that triangle. The upper stream is never on while the lower stream is off. With an index at or below 100, no level of magnitude 2 ever appears.
- R7: The reference is the table magnitude multiplied by `mod_idx_i` and divided by 128, so 256 means unity. With index 0, both cells stay at level 0.
- R8: The cell that receives the lower stream changes after every two fundamental periods. In a period where only the lower stream is active, exactly one cell is active, and whether consecutive periods use the same cell alternates from period to period.
- R9: The tuning words and the modulation index are captured in the first cycle after reset and at every accumulator wrap, never at any other time. A change made mid-period first shows at the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ftw_i | input | 32 | Fundamental phase increment per cycle |
| ctw_i | input | 12 | Carrier triangle step per cycle |
| mod_idx_i | input | 9 | Modulation index, 256 = unity |
| gate_o | output | 8 | Gate drives, four per cell |

## Verification
Every internal decision reaches `gate_o` through a single output register. A period start therefore shows on the pins one cycle after the accumulator wraps, and a sample taken there corresponds to phase zero. A new index presented during a period is captured at the next wrap, so its effect is due at the first sample of the following period. The bench locks onto a period edge by watching the zero-state switches toggle while the index is zero. From that edge it counts windows of exactly 1024 samples, taken at falling edges, so each window maps one-to-one onto a fundamental period.

// File: rtl/hpwm_pkg.sv
// Shared defaults and the per-cell gate structure for the hybrid PWM generator.
package hpwm_pkg;
    localparam int PH_W_DEF   = 32;  // phase accumulator width
    localparam int Q_BITS_DEF = 8;   // quarter-wave table address bits
    localparam int AMP_W_DEF  = 12;  // table and carrier amplitude width
    localparam int MI_W_DEF   = 9;   // modulation index width
    localparam int STEP_W_DEF = 12;  // carrier step width
    localparam int CELLS      = 2;   // five-level topology: two bridges

    // Gates of one bridge, packed so that the left upper switch is bit 0.
    typedef struct packed {
        logic r_lo;
        logic r_hi;
        logic l_lo;
        logic l_hi;
    } bridge_gates_t;
endpackage

// File: rtl/hpwm_phase_acc.sv
// Phase accumulator for the fundamental reference.
// Adds the step every cycle and flags the carry out, which marks a period start.
// Assumes the step is held stable by the caller between wraps.
module hpwm_phase_acc #(
    parameter int PH_W  = 32,
    parameter int TOP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   step_i,
    output logic [TOP_W-1:0]  ph_top_o,
    output logic              wrap_o
);
    logic [PH_W-1:0] acc;
    logic [PH_W:0]   nxt;

    assign nxt      = {1'b0, acc} + {1'b0, step_i};
    assign wrap_o   = nxt[PH_W];
    assign ph_top_o = acc[PH_W-1 -: TOP_W];

    // Advance the phase by one step.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= nxt[PH_W-1:0];
    end
endmodule

// File: rtl/hpwm_cycle_ctrl.sv
// Period-rate control: the sequential pulse, the stream-swap select, and the
// parameter capture strobe. Assumes wrap_i is a single-cycle pulse per period.
module hpwm_cycle_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    output logic seq_o,
    output logic swap_o,
    output logic load_o
);
    logic armed;

    assign load_o = ~armed | wrap_i;

    // Toggle the sequential pulse each period; toggle swap each second period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            seq_o  <= 1'b0;
            swap_o <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (wrap_i) begin
                seq_o <= ~seq_o;
                if (seq_o) swap_o <= ~swap_o;
            end
        end
    end
endmodule

// File: rtl/hpwm_sine_ref.sv
// Rectified sine reference. A quarter-wave table is filled at elaboration
// from a cubic approximation, mirrored over the half period, then scaled by
// the modulation index (2^(MI_W-1) is unity and gives a peak of two amplitudes).
// Assumes ph_i carries the top Q_BITS+2 bits of the phase.
module hpwm_sine_ref #(
    parameter int Q_BITS = 8,
    parameter int AMP_W  = 12,
    parameter int MI_W   = 9,
    localparam int REF_W = AMP_W + 2
) (
    input  logic [Q_BITS+1:0] ph_i,
    input  logic [MI_W-1:0]   mi_i,
    output logic [REF_W-1:0]  ref_o,
    output logic              pos_o
);
    localparam int QN      = 1 << Q_BITS;
    localparam int AMP_MAX = (1 << AMP_W) - 1;
    localparam int SHIFT   = MI_W - 2;

    // Table value for index idx: t*(3-t^2)/2 with t sampled at bin centres.
    function automatic logic [AMP_W-1:0] quarter_val(input int idx);
        longint n;
        longint u;
        longint num;
        longint den;
        n   = longint'(QN) * 2;
        u   = 2 * longint'(idx) + 1;
        num = longint'(AMP_MAX) * u * (3 * n * n - u * u);
        den = 2 * n * n * n;
        return AMP_W'(num / den);
    endfunction

    logic [AMP_W-1:0]      lut [QN];
    logic [Q_BITS-1:0]     addr;
    logic [AMP_W-1:0]      mag;
    logic [AMP_W+MI_W-1:0] prod;

    for (genvar i = 0; i < QN; i++) begin : g_lut
        assign lut[i] = quarter_val(i);
    end

    // Mirror the address in the falling quarter, then scale.
    always_comb begin
        addr  = ph_i[Q_BITS] ? ~ph_i[Q_BITS-1:0] : ph_i[Q_BITS-1:0];
        mag   = lut[addr];
        prod  = (AMP_W+MI_W)'(mag) * (AMP_W+MI_W)'(mi_i);
        ref_o = REF_W'(prod >> SHIFT);
        pos_o = ~ph_i[Q_BITS+1];
    end
endmodule

// File: rtl/hpwm_apod_carrier.sv
// Triangular carrier between 0 and full scale, plus two comparisons: the
// lower stream against the triangle, and the upper stream against a carrier
// raised by one amplitude and running in opposite phase.
// Assumes the step is no wider than the amplitude.
module hpwm_apod_carrier #(
    parameter int AMP_W  = 12,
    parameter int STEP_W = 12,
    localparam int REF_W = AMP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_i,
    input  logic [REF_W-1:0]  ref_i,
    output logic              pwm_lo_o,
    output logic              pwm_hi_o
);
    localparam int PEAK = (1 << AMP_W) - 1;

    logic [AMP_W-1:0] tri_cnt;
    logic             rising;
    logic [AMP_W:0]   up_sum;
    logic [REF_W-1:0] car_lo;
    logic [REF_W-1:0] car_hi;

    assign up_sum = {1'b0, tri_cnt} + (AMP_W+1)'(step_i);

    // Up/down count, clamping at either end and reversing there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tri_cnt <= '0;
            rising  <= 1'b1;
        end else if (rising) begin
            if (up_sum >= (AMP_W+1)'(PEAK)) begin
                tri_cnt <= AMP_W'(PEAK);
                rising  <= 1'b0;
            end else begin
                tri_cnt <= up_sum[AMP_W-1:0];
            end
        end else begin
            if ({1'b0, tri_cnt} <= (AMP_W+1)'(step_i)) begin
                tri_cnt <= '0;
                rising  <= 1'b1;
            end else begin
                tri_cnt <= tri_cnt - AMP_W'(step_i);
            end
        end
    end

    // Compare the reference against both stacked carriers.
    always_comb begin
        car_lo   = REF_W'(tri_cnt);
        car_hi   = REF_W'(2 * PEAK) - REF_W'(tri_cnt);
        pwm_lo_o = ref_i > car_lo;
        pwm_hi_o = ref_i > car_hi;
    end
endmodule

// File: rtl/hpwm_cell_gate.sv
// Gate logic of one bridge: polarity from the fundamental pulse, the resting
// zero state from the sequential pulse, active state from the PWM bit.
// Purely combinational; legs are always complementary.
module hpwm_cell_gate
    import hpwm_pkg::*;
(
    input  logic          seq_i,
    input  logic          pos_i,
    input  logic          pwm_i,
    output bridge_gates_t gates_o
);
    // Pick the leg that carries the PWM; the other rests at the seq level.
    always_comb begin
        gates_o.l_hi = pos_i ? (seq_i | pwm_i)  : (seq_i & ~pwm_i);
        gates_o.r_hi = pos_i ? (seq_i & ~pwm_i) : (seq_i | pwm_i);
        gates_o.l_lo = ~gates_o.l_hi;
        gates_o.r_lo = ~gates_o.r_hi;
    end
endmodule

// File: rtl/hpwm_gate_gen.sv
// Top of the hybrid PWM gate generator for a two-bridge five-level inverter.
// Captures its settings at each period start, builds the reference and the
// stacked carriers, rotates the two streams between bridges, and registers
// the eight gates. Dead time is added downstream.
module hpwm_gate_gen
    import hpwm_pkg::*;
#(
    parameter int PH_W   = PH_W_DEF,
    parameter int Q_BITS = Q_BITS_DEF,
    parameter int AMP_W  = AMP_W_DEF,
    parameter int MI_W   = MI_W_DEF,
    parameter int STEP_W = STEP_W_DEF,
    localparam int GATE_W = 4 * CELLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   ftw_i,
    input  logic [STEP_W-1:0] ctw_i,
    input  logic [MI_W-1:0]   mod_idx_i,
    output logic [GATE_W-1:0] gate_o
);
    localparam int TOP_W = Q_BITS + 2;
    localparam int REF_W = AMP_W + 2;
    localparam logic [GATE_W-1:0] GATE_SAFE = {CELLS{4'b1010}};

    logic [PH_W-1:0]   ftw_q;
    logic [STEP_W-1:0] ctw_q;
    logic [MI_W-1:0]   mi_q;
    logic [TOP_W-1:0]  ph_top;
    logic              wrap;
    logic              seq;
    logic              swap;
    logic              load;
    logic [REF_W-1:0]  ref_mag;
    logic              pos_half;
    logic              pwm_lo;
    logic              pwm_hi;
    logic [1:0]        pwm_set;
    logic [GATE_W-1:0] gate_d;

    hpwm_phase_acc #(.PH_W(PH_W), .TOP_W(TOP_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .step_i(ftw_q),
        .ph_top_o(ph_top), .wrap_o(wrap)
    );

    hpwm_cycle_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap),
        .seq_o(seq), .swap_o(swap), .load_o(load)
    );

    // Capture the settings only at a period start or just after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_q <= '0;
            ctw_q <= '0;
            mi_q  <= '0;
        end else if (load) begin
            ftw_q <= ftw_i;
            ctw_q <= ctw_i;
            mi_q  <= mod_idx_i;
        end
    end

    hpwm_sine_ref #(.Q_BITS(Q_BITS), .AMP_W(AMP_W), .MI_W(MI_W)) u_ref (
        .ph_i(ph_top), .mi_i(mi_q), .ref_o(ref_mag), .pos_o(pos_half)
    );

    hpwm_apod_carrier #(.AMP_W(AMP_W), .STEP_W(STEP_W)) u_car (
        .clk(clk), .rst_n(rst_n), .step_i(ctw_q), .ref_i(ref_mag),
        .pwm_lo_o(pwm_lo), .pwm_hi_o(pwm_hi)
    );

    assign pwm_set = {pwm_hi, pwm_lo};

    for (genvar k = 0; k < CELLS; k++) begin : g_cell
        localparam logic K1 = 1'(k);
        bridge_gates_t cell_gates;
        hpwm_cell_gate u_gate (
            .seq_i(seq), .pos_i(pos_half), .pwm_i(pwm_set[K1 ^ swap]),
            .gates_o(cell_gates)
        );
        assign gate_d[4*k +: 4] = cell_gates;
    end

    // Register the gates; reset holds every lower switch on.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_o <= GATE_SAFE;
        else        gate_o <= gate_d;
    end
endmodule

// File: rtl/hpwm_gate_gen_chk.sv
// Property checker for hpwm_gate_gen, attached by bind.
module hpwm_gate_gen_chk #(
    parameter int MI_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      gate_o,
    input logic            wrap,
    input logic            seq,
    input logic            swap,
    input logic            load,
    input logic [MI_W-1:0] mi_q,
    input logic            pwm_lo,
    input logic            pwm_hi
);
    a_r2_legs_complementary: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o[0] != gate_o[1]) && (gate_o[2] != gate_o[3]) &&
        (gate_o[4] != gate_o[5]) && (gate_o[6] != gate_o[7]));

    a_r6_upper_needs_lower: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_hi |-> pwm_lo);

    a_r7_zero_index_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
        (mi_q == '0) |=> ((gate_o[0] == gate_o[2]) && (gate_o[4] == gate_o[6])));

    a_r9_index_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mi_q));

    a_r5_seq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (seq != $past(seq)) |-> $past(wrap));

    a_r8_swap_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (swap != $past(swap)) |-> $fell(seq));
endmodule

bind hpwm_gate_gen hpwm_gate_gen_chk #(.MI_W(MI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate_o(gate_o), .wrap(wrap), .seq(seq),
    .swap(swap), .load(load), .mi_q(mi_q), .pwm_lo(pwm_lo), .pwm_hi(pwm_hi)
);

// File: tb/hpwm_gate_gen_tb_top.sv
// Directed bench for hpwm_gate_gen: one task per scenario.
module hpwm_gate_gen_tb_top;
    localparam int PERIOD = 1024;           // cycles per fundamental period
    localparam logic [31:0] FTW = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ftw = FTW;
    logic [11:0] ctw = 12'd256;
    logic [8:0]  mi = '0;
    logic [7:0]  g;

    int checks = 0;
    int errors = 0;
    int comp_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hpwm_gate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .ftw_i(ftw), .ctw_i(ctw),
        .mod_idx_i(mi), .gate_o(g)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lvl(input logic [3:0] c);
        return int'(c[0]) - int'(c[2]);
    endfunction

    // R2 monitor: count any leg whose two switches agree.
    always @(negedge clk) begin
        if (rst_n && ((g[0] == g[1]) || (g[2] == g[3]) || (g[4] == g[5]) || (g[6] == g[7])))
            comp_bad++;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        mi = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait for the zero-state switches to toggle (index zero): a period edge.
    task automatic sync_edge(output bit ok);
        logic prev;
        prev = g[0];
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (g[0] != prev) begin
                ok = 1'b1;
                return;
            end
        end
    endtask

    task automatic t_reset_state();
        bit ok;
        int nz;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(g == 8'hAA, "R3", "gates in reset", int'(g), 8'hAA);
        rst_n = 1'b1;
        nz = 0;
        repeat (100) begin
            @(negedge clk);
            if (lvl(g[3:0]) != 0 || lvl(g[7:4]) != 0) nz++;
        end
        chk(nz == 0, "R7", "nonzero samples after reset at index 0", nz, 0);
        sync_edge(ok);
        chk(ok, "R5", "first period edge seen", int'(ok), 1);
    endtask

    task automatic t_zero_index();
        bit ok;
        int n;
        int nz;
        int bad_rest;
        logic v0;
        do_reset();
        sync_edge(ok);
        v0 = g[0];
        for (int e = 0; e < 2; e++) begin
            n = 0;
            nz = 0;
            bad_rest = 0;
            for (int i = 1; i <= 3000; i++) begin
                @(negedge clk);
                if (g[0] != v0) begin
                    n = i;
                    break;
                end
                if (lvl(g[3:0]) != 0 || lvl(g[7:4]) != 0) nz++;
                if (g[2] != v0 || g[4] != v0 || g[6] != v0) bad_rest++;
            end
            chk(n == PERIOD, "R5", "cycles between zero-state toggles", n, PERIOD);
            chk(nz == 0, "R7", "nonzero samples at index 0", nz, 0);
            chk(bad_rest == 0, "R5", "upper switches not uniform in zero state", bad_rest, 0);
            v0 = g[0];
        end
    endtask

    task automatic t_five_levels();
        bit ok;
        bit seen[5];
        int sign_bad;
        int opp_bad;
        int nz0;
        int nz1;
        int stack_bad;
        int l0;
        int l1;
        logic [7:0] smp[PERIOD];
        do_reset();
        sync_edge(ok);
        mi = 9'd256;
        repeat (PERIOD - 1) @(negedge clk);
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            smp[i] = g;
        end
        foreach (seen[j]) seen[j] = 1'b0;
        sign_bad = 0;
        opp_bad = 0;
        nz0 = 0;
        nz1 = 0;
        for (int i = 0; i < PERIOD; i++) begin
            l0 = lvl(smp[i][3:0]);
            l1 = lvl(smp[i][7:4]);
            if ((l0 + l1) >= -2 && (l0 + l1) <= 2) seen[l0 + l1 + 2] = 1'b1;
            if (i < PERIOD / 2 && (l0 < 0 || l1 < 0)) sign_bad++;
            if (i >= PERIOD / 2 && (l0 > 0 || l1 > 0)) sign_bad++;
            if (l0 * l1 < 0) opp_bad++;
            if (l0 != 0) nz0++;
            if (l1 != 0) nz1++;
        end
        for (int j = 0; j < 5; j++)
            chk(seen[j], "R1", $sformatf("level %0d seen", j - 2), int'(seen[j]), 1);
        chk(sign_bad == 0, "R4", "samples with wrong polarity for half", sign_bad, 0);
        chk(opp_bad == 0, "R4", "samples with opposite cell polarity", opp_bad, 0);
        stack_bad = 0;
        for (int i = 0; i < PERIOD; i++) begin
            l0 = lvl(smp[i][3:0]);
            l1 = lvl(smp[i][7:4]);
            if (nz0 >= nz1 && l1 != 0 && l0 == 0) stack_bad++;
            if (nz1 > nz0 && l0 != 0 && l1 == 0) stack_bad++;
        end
        chk(stack_bad == 0, "R6", "upper stream on while lower off", stack_bad, 0);
    endtask

    task automatic t_rotation();
        bit ok;
        int nz0;
        int nz1;
        int big;
        int alt_bad;
        bit s[8];
        bit t[7];
        do_reset();
        sync_edge(ok);
        mi = 9'd100;
        repeat (PERIOD - 1) @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            nz0 = 0;
            nz1 = 0;
            big = 0;
            for (int i = 0; i < PERIOD; i++) begin
                @(negedge clk);
                if (lvl(g[3:0]) != 0) nz0++;
                if (lvl(g[7:4]) != 0) nz1++;
                if ((lvl(g[3:0]) + lvl(g[7:4]) > 1) || (lvl(g[3:0]) + lvl(g[7:4]) < -1)) big++;
            end
            chk((nz0 > 0) != (nz1 > 0), "R8", $sformatf("one active cell in period %0d", p),
                nz0 * 10000 + nz1, 1);
            chk(big == 0, "R6", $sformatf("magnitude-2 samples at index 100, period %0d", p), big, 0);
            s[p] = nz1 > 0;
        end
        for (int p = 0; p < 7; p++) t[p] = s[p] != s[p + 1];
        alt_bad = 0;
        for (int p = 0; p < 6; p++) if (t[p] == t[p + 1]) alt_bad++;
        chk(alt_bad == 0, "R8", "stream swap not every second period", alt_bad, 0);
    endtask

    task automatic t_midcycle_update();
        bit ok;
        int nz;
        do_reset();
        sync_edge(ok);
        repeat (500) @(negedge clk);
        mi = 9'd256;
        nz = 0;
        repeat (PERIOD - 501) begin
            @(negedge clk);
            if (lvl(g[3:0]) != 0 || lvl(g[7:4]) != 0) nz++;
        end
        chk(nz == 0, "R9", "index applied mid-period", nz, 0);
        nz = 0;
        repeat (PERIOD) begin
            @(negedge clk);
            if (lvl(g[3:0]) != 0 || lvl(g[7:4]) != 0) nz++;
        end
        chk(nz > 0, "R9", "index applied at next period start", nz, 1);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_zero_index();
        t_five_levels();
        t_rotation();
        t_midcycle_update();
        chk(comp_bad == 0, "R2", "legs with equal switches", comp_bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule